// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a qualified three-level PWM command into the two gate enables of a synchronous buck half-bridge: `hs_gate` for the high-side switch and `ls_gate` for the low-side switch. It combines that command with an active-low skip input, an active-low disable input and a supply-good flag. The supply-good flag is an already-debounced digital input. Its hysteresis is produced outside the block.

The block never switches one side on just because the command changed. A switch turns on only after a digital comparator flag reports that the opposite side is off, and after that flag has been held for a programmable number of clock cycles. The low side has a second route to turn-on. Once the high-side gate-source voltage is seen below its threshold, a longer timeout starts. When the timeout expires, the low side is switched on even if the switch node never fell, so the bootstrap capacitor still gets recharged every cycle. With skip held low, the block runs in diode emulation: the low side stays off and the high side still follows the command.

All delays are given in clock cycles. Both outputs are registered, so a change on any input shows up at the outputs one clock edge later.

Top module: `gate_sequencer`

## Requirements
- R1: While `supply_ok` is low or `off_n` is low at a clock edge, both `hs_gate` and `ls_gate` are low after that edge, whatever the other inputs are.
- R2: `pwm_cmd` uses 2'b00 for LOW, 2'b01 for HIGH, and 2'b10 or 2'b11 for SHUTDOWN. A SHUTDOWN command sampled at an edge leaves both gates low after that edge, for either level of `skip_n`.
- R3: `hs_gate` is low after any edge at which `pwm_cmd` is not HIGH. While HIGH is held, `hs_gate` goes high through the wait described in R6.
- R4: `ls_gate` is low after any edge at which `pwm_cmd` is not LOW. While LOW is held with `skip_n` high, `ls_gate` goes high through the wait described in R7 or R8.
- R5: While `skip_n` is low, `ls_gate` is low after every edge, and `hs_gate` still behaves as in R3.
- R6: A high-side wait begins at the edge where HIGH is first accepted. `hs_gate` rises at the DEAD_ON-th consecutive later edge that samples `lsg_below` high. An edge with `lsg_below` low restarts the run.
- R7: A low-side wait begins at the edge where LOW with `skip_n` high is first accepted. `ls_gate` rises at the DEAD_OFF-th consecutive later edge that samples `sw_below` high. An edge with `sw_below` low restarts the run.
- R8: In a low-side wait, the first later edge that samples `hsvgs_below` high arms a timeout. That edge counts as one, and every later edge counts whatever `hsvgs_below` does. `ls_gate` rises at the count equal to the effective timeout, even if `sw_below` stays low.
- R9: The effective timeout is TIMEOUT when TIMEOUT exceeds DEAD_OFF. Otherwise it is DEAD_OFF+1.
- R10: `hs_gate` and `ls_gate` are never high together. Each gate rises only after a cycle in which the other gate was low.
- R11: If `skip_n` rises while LOW is held, or the block is re-enabled with LOW held, `ls_gate` stays low until the R7 or R8 condition is met.
- R12: While reset is asserted, both gates are low and no wait is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Supply-good (undervoltage lockout released) |
| off_n | input | 1 | Active-low disable |
| pwm_cmd | input | 2 | Qualified command: 00 LOW, 01 HIGH, 1x SHUTDOWN |
| skip_n | input | 1 | Active-low skip (diode emulation when low) |
| lsg_below | input | 1 | Low-side gate sensed below threshold |
| sw_below | input | 1 | Switch node sensed below threshold |
| hsvgs_below | input | 1 | High-side gate-source voltage sensed below threshold |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
The hardest situation to reach from the ports is a timeout turn-on. It needs a low-side wait in which `sw_below` never reaches DEAD_OFF consecutive samples, and a `hsvgs_below` pulse that arms the timeout and then goes away. Directed stimulus pulses `hsvgs_below` for one cycle while holding `sw_below` low, then checks the exact edge at which `ls_gate` rises. A long random phase breaks up sensing runs, swaps commands in the middle of a wait and toggles the enables. Every edge is compared with a behavioural model of the wait counts.

// File: rtl/gate_sequencer.sv
module gate_sequencer #(
  parameter int DEAD_ON  = 2,
  parameter int DEAD_OFF = 3,
  parameter int TIMEOUT  = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       off_n,
  input  logic [1:0] pwm_cmd,
  input  logic       skip_n,
  input  logic       lsg_below,
  input  logic       sw_below,
  input  logic       hsvgs_below,
  output logic       hs_gate,
  output logic       ls_gate
);
  localparam int TMO_EFF = (TIMEOUT > DEAD_OFF) ? TIMEOUT : DEAD_OFF + 1;
  localparam int CMAX    = (DEAD_ON > TMO_EFF) ? DEAD_ON : TMO_EFF;
  localparam int CW      = $clog2(CMAX + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_HWAIT, ST_HON, ST_LWAIT, ST_LON} st_t;

  st_t           st;
  logic [CW-1:0] dcnt;
  logic [CW-1:0] tcnt;
  logic          tarm;

  logic active, want_h, want_l, hit_h, hit_l, tmo_go, tmo_hit;

  assign active  = supply_ok & off_n;
  assign want_h  = active && (pwm_cmd == 2'b01);
  assign want_l  = active && (pwm_cmd == 2'b00) && skip_n;
  assign hit_h   = lsg_below && (dcnt == CW'(DEAD_ON - 1));
  assign hit_l   = sw_below && (dcnt == CW'(DEAD_OFF - 1));
  assign tmo_go  = tarm | hsvgs_below;
  assign tmo_hit = tmo_go && (tcnt == CW'(TMO_EFF - 1));

  assign hs_gate = (st == ST_HON);
  assign ls_gate = (st == ST_LON);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      dcnt <= '0;
      tcnt <= '0;
      tarm <= 1'b0;
    end else if (want_h) begin
      tarm <= 1'b0;
      tcnt <= '0;
      case (st)
        ST_HON: dcnt <= '0;
        ST_HWAIT: begin
          if (hit_h) begin
            st   <= ST_HON;
            dcnt <= '0;
          end else begin
            dcnt <= lsg_below ? dcnt + CW'(1) : '0;
          end
        end
        default: begin
          st   <= ST_HWAIT;
          dcnt <= '0;
        end
      endcase
    end else if (want_l) begin
      case (st)
        ST_LON: begin
          dcnt <= '0;
          tcnt <= '0;
          tarm <= 1'b0;
        end
        ST_LWAIT: begin
          if (hit_l || tmo_hit) begin
            st   <= ST_LON;
            dcnt <= '0;
            tcnt <= '0;
            tarm <= 1'b0;
          end else begin
            dcnt <= sw_below ? dcnt + CW'(1) : '0;
            if (tmo_go) begin
              tarm <= 1'b1;
              tcnt <= tcnt + CW'(1);
            end
          end
        end
        default: begin
          st   <= ST_LWAIT;
          dcnt <= '0;
          tcnt <= '0;
          tarm <= 1'b0;
        end
      endcase
    end else begin
      st   <= ST_IDLE;
      dcnt <= '0;
      tcnt <= '0;
      tarm <= 1'b0;
    end
  end
endmodule

// File: rtl/gate_sequencer_chk.sv
module gate_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       off_n,
  input logic [1:0] pwm_cmd,
  input logic       skip_n,
  input logic       lsg_below,
  input logic       hs_gate,
  input logic       ls_gate
);
  assert_disable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok || !off_n) |=> (!hs_gate && !ls_gate));
  assert_shutdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_cmd[1] |=> (!hs_gate && !ls_gate));
  assert_hs_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_cmd != 2'b01) |=> !hs_gate);
  assert_ls_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_cmd != 2'b00) |=> !ls_gate);
  assert_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_n |=> !ls_gate);
  assert_hs_sensed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> $past(lsg_below));
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));
  assert_hs_break_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> $past(!ls_gate));
  assert_ls_break_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> $past(!hs_gate));
endmodule

bind gate_sequencer gate_sequencer_chk chk (.*);

// File: tb/gate_sequencer_test.sv
module gate_sequencer_test;
  localparam int DON = 2, DOFF = 3, TMO = 25;
  localparam int TEFF = (TMO > DOFF) ? TMO : DOFF + 1;

  logic clk = 0, rst_n = 0, supply_ok = 1, off_n = 1, skip_n = 1;
  logic lsg_below = 0, sw_below = 0, hsvgs_below = 0;
  logic [1:0] pwm_cmd = 2'b10;
  logic hs_gate, ls_gate;
  int compared = 0, mismatched = 0;
  string cur_req = "R12";

  always #5 clk = ~clk;

  gate_sequencer #(.DEAD_ON(DON), .DEAD_OFF(DOFF), .TIMEOUT(TMO)) uut (.*);

  // behavioural reference
  bit eh, el, hw, lw, ta;
  int hq, lq, tq;

  task automatic chk(string req, logic got, logic exp, string what);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit ok, wh, wl;
    if (!rst_n) begin
      eh = 0; el = 0; hw = 0; lw = 0; ta = 0; hq = 0; lq = 0; tq = 0;
    end else begin
      ok = supply_ok && off_n;
      wh = ok && pwm_cmd == 2'b01;
      wl = ok && pwm_cmd == 2'b00 && skip_n;
      if (wh) begin
        el = 0; lw = 0;
        if (!eh) begin
          if (!hw) begin hw = 1; hq = 0; end
          else begin
            hq = lsg_below ? hq + 1 : 0;
            if (hq >= DON) begin eh = 1; hw = 0; end
          end
        end
      end else if (wl) begin
        eh = 0; hw = 0;
        if (!el) begin
          if (!lw) begin lw = 1; lq = 0; tq = 0; ta = 0; end
          else begin
            lq = sw_below ? lq + 1 : 0;
            if (hsvgs_below) ta = 1;
            if (ta) tq++;
            if (lq >= DOFF || tq >= TEFF) begin el = 1; lw = 0; end
          end
        end
      end else begin
        eh = 0; el = 0; hw = 0; lw = 0;
      end
    end
    #4;
    if (rst_n) begin
      chk(cur_req, hs_gate, eh, "hs_gate");
      chk(cur_req, ls_gate, el, "ls_gate");
      if (hs_gate && ls_gate) chk("R10", 1'b1, 1'b0, "both gates high");
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    step(3);
    chk("R12", hs_gate, 1'b0, "hs in reset");
    chk("R12", ls_gate, 1'b0, "ls in reset");
    rst_n = 1;

    // R3 / R6: high-side wait, exact edge
    cur_req = "R6"; pwm_cmd = 2'b01; lsg_below = 1;
    step(DON);  chk("R6", hs_gate, 1'b0, "hs before dead-on");
    step(1);    chk("R6", hs_gate, 1'b1, "hs after dead-on");
    step(5);
    // R6 restart when sense drops
    cur_req = "R6"; pwm_cmd = 2'b10; step(2);
    pwm_cmd = 2'b01; lsg_below = 1; step(2); lsg_below = 0; step(3); lsg_below = 1; step(6);
    cur_req = "R3"; pwm_cmd = 2'b00; skip_n = 0; step(1);
    chk("R3", hs_gate, 1'b0, "hs after leaving HIGH");

    // R7: low-side via switch-node sense
    cur_req = "R7"; skip_n = 1; sw_below = 1; step(DOFF + 4);
    chk("R7", ls_gate, 1'b1, "ls after dead-off");
    cur_req = "R4"; pwm_cmd = 2'b01; lsg_below = 0; step(1);
    chk("R4", ls_gate, 1'b0, "ls after leaving LOW");
    step(4);

    // R8 / R9: timeout path, exact edge
    cur_req = "R8"; pwm_cmd = 2'b00; sw_below = 0; hsvgs_below = 0; step(1);
    hsvgs_below = 1; step(1); hsvgs_below = 0;
    step(TEFF - 2); chk("R9", ls_gate, 1'b0, "ls before timeout");
    step(1);        chk("R8", ls_gate, 1'b1, "ls at timeout");
    step(3);

    // R5: diode emulation
    cur_req = "R5"; skip_n = 0; sw_below = 1; hsvgs_below = 1; step(30);
    chk("R5", ls_gate, 1'b0, "ls with skip low");
    pwm_cmd = 2'b01; lsg_below = 1; step(DON + 2);
    chk("R5", hs_gate, 1'b1, "hs with skip low");

    // R11: skip rises while LOW, sensing withheld
    cur_req = "R11"; pwm_cmd = 2'b00; sw_below = 0; hsvgs_below = 0; step(3);
    skip_n = 1; step(10);
    chk("R11", ls_gate, 1'b0, "ls waits for sense");
    sw_below = 1; step(DOFF + 1);
    chk("R11", ls_gate, 1'b1, "ls after sense");

    // R2: shutdown with both skip levels
    cur_req = "R2"; pwm_cmd = 2'b10; step(1);
    chk("R2", ls_gate, 1'b0, "shutdown skip high");
    skip_n = 0; pwm_cmd = 2'b11; step(3);
    chk("R2", hs_gate, 1'b0, "shutdown skip low");

    // R1: disables while on
    cur_req = "R1"; skip_n = 1; pwm_cmd = 2'b01; step(6);
    supply_ok = 0; step(1);
    chk("R1", hs_gate, 1'b0, "supply low");
    supply_ok = 1; step(6); off_n = 0; step(1);
    chk("R1", hs_gate, 1'b0, "disable low");
    cur_req = "R11"; pwm_cmd = 2'b00; sw_below = 0; step(4); off_n = 1; step(5);
    chk("R11", ls_gate, 1'b0, "ls after re-enable before sense");
    sw_below = 1; step(6);

    // R10: random mix
    cur_req = "R10";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 7) == 0) pwm_cmd = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) skip_n = ~skip_n;
      if ($urandom_range(0, 40) == 0) supply_ok = ~supply_ok;
      if ($urandom_range(0, 40) == 0) off_n = ~off_n;
      if (!supply_ok && $urandom_range(0, 3) == 0) supply_ok = 1;
      if (!off_n && $urandom_range(0, 3) == 0) off_n = 1;
      lsg_below   = ($urandom_range(0, 3) != 0);
      sw_below    = ($urandom_range(0, 2) == 0);
      hsvgs_below = ($urandom_range(0, 9) == 0);
      step(1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule